// File: doc/BRIEF.md
# Nonvolatile Command Chain Detector

This block sits beside a 32K x 8 SRAM access port and watches the stream of accesses, one valid pulse per access, in a synchronous clock domain. Software asks for a copy of the whole SRAM into nonvolatile shadow storage, or a copy back from it, by issuing six plain reads from a fixed list of addresses. The detector spots that chain and raises a one-cycle request pulse toward the unit that performs the transfer.

The five leading addresses are common to both commands. The sixth address selects the operation. A write, or a read from any address off the expected path, breaks the chain. After a request has been issued, the detector ignores all accesses until the transfer unit reports completion. It then looks for a new chain from the beginning.

Top module: `nv_cmd_detect`

## Requirements
- R1: During reset and in the first cycle after it, `storeReq` and `recallReq` are both low and the chain is empty.
- R2: Six valid reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 make `storeReq` high for exactly the one cycle after the clock edge that samples the sixth read.
- R3: The same five leading reads followed by a read at 0x0C63 make `recallReq` high for exactly the one cycle after the sixth read is sampled.
- R4: A valid access with `accWrite` high aborts a partial chain at any step, including a write to a chain address. Completing the remaining reads then produces no request.
- R5: A valid read at an address that is not the next expected one aborts the chain, and no request follows.
- R6: A valid read at 0x0E38 that breaks a partial chain counts as the first step of a new chain. The four remaining leading reads plus a final read then complete a command.
- R7: Cycles with `accValid` low neither advance nor abort the chain. Each valid pulse moves the chain by at most one step.
- R8: After a request, every access is ignored until `opDone` is sampled high. A full chain issued before that produces no request. A full chain issued after it is detected normally.
- R9: `storeReq` and `recallReq` are never high together. Neither is high for two consecutive cycles.
- R10: Only exact 15-bit matches count. An address that differs in one bit from the expected one aborts the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | One-cycle pulse marking an access |
| accWrite | input | 1 | High for a write, low for a read; used when accValid is high |
| accAddr | input | 15 | Word address of the access |
| opDone | input | 1 | Transfer unit reports that the requested operation finished |
| storeReq | output | 1 | One-cycle request to copy SRAM into shadow storage |
| recallReq | output | 1 | One-cycle request to copy shadow storage into SRAM |

## Verification
The hardest situations to reach from the ports are a chain that is five steps deep and is then broken, either by a restart read at 0x0E38 or by a near-miss address, and a complete chain that arrives while an earlier request is still waiting for `opDone`. The stimulus therefore builds complete chains on purpose and injects noise between steps with a chosen probability: idle gaps, writes, stray reads and restart reads. `opDone` is held back for a random number of cycles so that chains land inside the hold window. Directed sequences cover each of these cases once before the random phase starts.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int ADDR_W    = 15;
  localparam int CHAIN_LEN = 6;
  localparam int LAST_STEP = CHAIN_LEN - 1;
  localparam int STEP_W    = $clog2(CHAIN_LEN);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam addr_t STORE_ADDR  = 15'h0FC0;
  localparam addr_t RECALL_ADDR = 15'h0C63;

  // Leading addresses shared by both commands, indexed by chain step.
  function automatic addr_t prefixAddr(input step_t idx);
    case (idx)
      step_t'(0): prefixAddr = 15'h0E38;
      step_t'(1): prefixAddr = 15'h31C7;
      step_t'(2): prefixAddr = 15'h03E0;
      step_t'(3): prefixAddr = 15'h3C1F;
      step_t'(4): prefixAddr = 15'h303F;
      default:    prefixAddr = '0;
    endcase
  endfunction

  typedef struct packed {
    logic advance;
    logic restart;
    logic clear;
  } stepCtl_t;

  typedef struct packed {
    logic hitNext;
    logic hitFirst;
    logic hitStore;
    logic hitRecall;
  } matchFlags_t;

  typedef enum logic {
    MODE_SEEK = 1'b0,
    MODE_HOLD = 1'b1
  } mode_e;
endpackage

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  addr_t       accAddr,
  input  stepCtl_t    ctl,
  output matchFlags_t flags
);
  step_t stepCnt;
  addr_t expectAddr;
  logic  atLast;

  always_comb begin
    expectAddr      = prefixAddr(stepCnt);
    atLast          = (stepCnt == step_t'(LAST_STEP));
    flags.hitNext   = !atLast && (accAddr == expectAddr);
    flags.hitFirst  = (accAddr == prefixAddr(step_t'(0)));
    flags.hitStore  = atLast && (accAddr == STORE_ADDR);
    flags.hitRecall = atLast && (accAddr == RECALL_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            stepCnt <= '0;
    else if (ctl.clear)   stepCnt <= '0;
    else if (ctl.restart) stepCnt <= step_t'(1);
    else if (ctl.advance) stepCnt <= stepCnt + step_t'(1);
  end

  // R7: the control asks for at most one step change per cycle
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.advance, ctl.restart, ctl.clear}));

  // R2: the step count never leaves the chain
  p_step_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= step_t'(LAST_STEP));

  // R5: an advance is only requested below the last step
  p_adv_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (stepCnt < step_t'(LAST_STEP)));
endmodule

// File: rtl/nvseq_control.sv
module nvseq_control
  import nvseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        opDone,
  input  matchFlags_t flags,
  output stepCtl_t    ctl,
  output logic        storeReq,
  output logic        recallReq
);
  mode_e mode, modeNext;
  logic  fireStore, fireRecall;

  always_comb begin
    ctl        = '0;
    fireStore  = 1'b0;
    fireRecall = 1'b0;
    modeNext   = mode;
    if (mode == MODE_HOLD) begin
      if (opDone) begin
        modeNext  = MODE_SEEK;
        ctl.clear = 1'b1;
      end
    end else if (accValid) begin
      if (accWrite) begin
        ctl.clear = 1'b1;
      end else if (flags.hitNext) begin
        ctl.advance = 1'b1;
      end else if (flags.hitStore) begin
        fireStore = 1'b1;
        ctl.clear = 1'b1;
        modeNext  = MODE_HOLD;
      end else if (flags.hitRecall) begin
        fireRecall = 1'b1;
        ctl.clear  = 1'b1;
        modeNext   = MODE_HOLD;
      end else if (flags.hitFirst) begin
        ctl.restart = 1'b1;
      end else begin
        ctl.clear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_SEEK;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      mode      <= modeNext;
      storeReq  <= fireStore;
      recallReq <= fireRecall;
    end
  end

  // R9: the two requests are mutually exclusive
  p_excl_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R9: a request lasts a single cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |=> !(storeReq || recallReq));

  // R8: a request is always accompanied by the hold mode
  p_req_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> (mode == MODE_HOLD));
endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
  import nvseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              opDone,
  output logic              storeReq,
  output logic              recallReq
);
  stepCtl_t    ctl;
  matchFlags_t flags;

  nvseq_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .accAddr (accAddr),
    .ctl     (ctl),
    .flags   (flags)
  );

  nvseq_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .opDone    (opDone),
    .flags     (flags),
    .ctl       (ctl),
    .storeReq  (storeReq),
    .recallReq (recallReq)
  );

  // R2: a store request follows a sampled read at the store address
  p_store_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(accValid && !accWrite && accAddr == STORE_ADDR));

  // R3: a recall request follows a sampled read at the recall address
  p_recall_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> $past(accValid && !accWrite && accAddr == RECALL_ADDR));
endmodule

// File: tb/nv_cmd_detect_bench.sv
`timescale 1ns/1ps
module nv_cmd_detect_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [14:0] accAddr = '0;
  logic        opDone = 1'b0;
  logic        storeReq, recallReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  int mStep = 0;
  bit mHold = 0;

  always #4 clk = ~clk;

  nv_cmd_detect u_nv_cmd_detect (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .opDone(opDone), .storeReq(storeReq), .recallReq(recallReq)
  );

  function automatic logic [14:0] chainAddr(int idx);
    case (idx)
      0: return 15'h0E38;
      1: return 15'h31C7;
      2: return 15'h03E0;
      3: return 15'h3C1F;
      4: return 15'h303F;
      5: return 15'h0FC0;
      default: return 15'h0C63;
    endcase
  endfunction

  // Expected outputs for one sampled cycle; updates the model state.
  function automatic logic [1:0] modelStep(bit v, bit w, logic [14:0] a, bit d);
    logic [1:0] res = 2'b00;
    if (mHold) begin
      if (d) begin mHold = 0; mStep = 0; end
    end else if (v) begin
      if (w) mStep = 0;
      else if (mStep < 5 && a == chainAddr(mStep)) mStep++;
      else if (mStep == 5 && a == 15'h0FC0) begin res = 2'b10; mHold = 1; mStep = 0; end
      else if (mStep == 5 && a == 15'h0C63) begin res = 2'b01; mHold = 1; mStep = 0; end
      else if (a == chainAddr(0)) mStep = 1;
      else mStep = 0;
    end
    return res;
  endfunction

  task automatic check(bit expS, bit expR);
    checks++;
    if (storeReq !== expS || recallReq !== expR) begin
      fails++;
      $display("FAIL %s: store/recall actual %b%b expected %b%b at %0t",
               curReq, storeReq, recallReq, expS, expR, $time);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, check.
  task automatic cyc(bit v, bit w, logic [14:0] a, bit d);
    logic [1:0] e;
    accValid = v; accWrite = w; accAddr = a; opDone = d;
    e = modelStep(v, w, a, d);
    @(negedge clk);
    check(e[1], e[0]);
  endtask

  task automatic rd(logic [14:0] a);
    cyc(1, 0, a, 0);
  endtask

  task automatic prefix();
    for (int i = 0; i < 5; i++) rd(chainAddr(i));
  endtask

  task automatic finishOp();
    cyc(0, 0, '0, 0);
    cyc(0, 0, '0, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(0, 0);
    rstN = 1'b1;
    cyc(0, 0, '0, 0);

    curReq = "R2"; prefix(); rd(15'h0FC0); finishOp();
    curReq = "R3"; prefix(); rd(15'h0C63); finishOp();

    curReq = "R4";
    rd(chainAddr(0)); rd(chainAddr(1)); cyc(1, 1, chainAddr(2), 0);
    rd(chainAddr(2)); rd(chainAddr(3)); rd(chainAddr(4)); rd(15'h0FC0);
    prefix(); cyc(1, 1, 15'h0FC0, 0); rd(15'h0FC0);

    curReq = "R5";
    prefix(); rd(15'h1234); rd(15'h0C63);
    rd(chainAddr(0)); rd(chainAddr(1)); rd(chainAddr(3));
    rd(chainAddr(3)); rd(chainAddr(4)); rd(15'h0FC0);

    curReq = "R6";
    prefix(); rd(chainAddr(0));
    for (int i = 1; i < 5; i++) rd(chainAddr(i));
    rd(15'h0C63); finishOp();
    rd(chainAddr(0)); rd(chainAddr(1)); rd(chainAddr(0));
    for (int i = 1; i < 5; i++) rd(chainAddr(i));
    rd(15'h0FC0); finishOp();

    curReq = "R7";
    for (int i = 0; i < 5; i++) begin
      rd(chainAddr(i));
      cyc(0, 1, 15'h7FFF, 0);
      cyc(0, 0, 15'h1111, 0);
    end
    rd(15'h0C63); finishOp();

    curReq = "R8";
    prefix(); rd(15'h0FC0);
    prefix(); rd(15'h0C63); cyc(1, 1, 15'h0000, 0);
    cyc(0, 0, '0, 1);
    prefix(); rd(15'h0C63); finishOp();

    curReq = "R10";
    prefix(); rd(15'h0FC1);
    prefix(); rd(15'h4C63);
    rd(chainAddr(0)); rd(chainAddr(1) ^ 15'h0100); rd(chainAddr(2));
    rd(chainAddr(3)); rd(chainAddr(4)); rd(15'h0FC0);

    curReq = "R9";
    for (int n = 0; n < 400; n++) begin
      for (int s = 0; s < 6; s++) begin
        int r = $urandom_range(0, 99);
        if (r < 8) cyc(0, $urandom_range(0, 1), 15'($urandom), 0);
        else if (r < 11) cyc(1, 1, chainAddr(s), 0);
        else if (r < 14) rd(15'($urandom));
        else if (r < 17) rd(chainAddr(0));
        else if (r < 19) rd(chainAddr(s) ^ (15'd1 << $urandom_range(0, 14)));
        if (s < 5) rd(chainAddr(s));
        else rd($urandom_range(0, 1) ? 15'h0FC0 : 15'h0C63);
      end
      cyc(0, 0, '0, ($urandom_range(0, 99) < 40));
    end
    repeat (4) cyc(0, 0, '0, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule